// File: doc/BRIEF.md
# NOR Flash Busy-Status Responder

This block builds the byte a parallel NOR flash returns on its data lines when the host reads it while the internal program/erase engine is working. The engine itself and the cell array are outside the block. Their state comes in on plain ports: an operation code, a failure flag, the data bit being written, an erase-running flag and a suspend-settled flag. The array's read data also comes in, along with a flag saying whether the current read address falls inside a block that is being erased.

For every read, the block chooses between array data and a status byte. The status byte carries a completion bit, two toggle bits, an error bit, an erase-timer bit and an abort bit. The toggle bits depend on how many reads have happened since the operation started. One of them also depends on where the read lands. Both toggle bits are held in flip-flops that change once per host read. The host polls the byte until the toggling stops, which tells it the operation has finished.

Top module: `nor_status_responder`

## Requirements
- R1: With code 0 (idle) or 7 (treated as idle) on `op_state` and no abort latched, `dout` equals `arr_data` on all bits.
- R2: With code 1 (program), status bit 7 is the inverse of `prog_bit`.
- R3: With codes 2 (block erase), 3 (chip erase) and 4 (blank check), status bit 7 reads 0.
- R4: Under codes 1 to 4, status bit 6 inverts after every read, whatever `rd_in_erase_blk` is. The first read after an operation starts returns 0.
- R5: Under codes 1 to 4, status bit 5 equals `op_fail`. It reads 0 in suspend and abort.
- R6: Status bit 3 follows `erase_running` under code 2. It is 1 under code 3 and under code 5 (erase suspended), and 0 otherwise.
- R7: Status bit 2 inverts after each read with `rd_in_erase_blk`=1 under codes 2, 3 and 5. Every other read leaves it unchanged.
- R8: Under code 5, a read with `rd_in_erase_blk`=0 returns `arr_data`.
- R9: Under code 5, a read with `rd_in_erase_blk`=1 returns status with bit 7 at 0. Bit 6 inverts per read while `suspend_done`=0 and holds once it is 1.
- R10: Code 6 (buffered-program abort) latches an abort state. The status then shows bit 1 at 1, bit 7 as the inverse of `prog_bit`, and bit 6 frozen. It persists through other codes until a one-cycle `abort_rst` pulse clears it.
- R11: Whenever status is driven, bits 4 and 0 and every bit above 7 read 0, and bit 1 is 0 outside abort.
- R12: Both toggle bits clear to 0 when a code from 1 to 4 follows code 0 or 7. A resume from code 5 to code 2 or 3 does not clear them.
- R13: A read is the rising edge of `rd_strobe`. A strobe held high for several cycles counts as one read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_state | input | 3 | Engine state code: 0 idle, 1 program, 2 block erase, 3 chip erase, 4 blank check, 5 erase suspended, 6 buffered-program abort, 7 idle |
| op_fail | input | 1 | Current operation has failed |
| prog_bit | input | 1 | Bit 7 of the data being programmed |
| erase_running | input | 1 | Block erase has left its block-collection window |
| suspend_done | input | 1 | Erase suspend has taken effect |
| abort_rst | input | 1 | One-cycle pulse that leaves the abort state |
| rd_strobe | input | 1 | Host read strobe |
| rd_in_erase_blk | input | 1 | Read address lies in a block being erased |
| arr_data | input | DW | Array read data |
| dout | output | DW | Status byte (zero-extended) or array data |

## Verification
The toggle flip-flops are the only hidden state besides the abort latch, so a fault in them can stay invisible for a long time. A toggle that misses one read, flips twice, or fails to clear at an operation start shows up at the very next status read as bit 6 or bit 2 holding the wrong phase. From then on it is wrong on every later read until the next clear. A stuck abort latch shows up on the first idle read as status where array data was expected, and a latch that never sets shows up on the read right after the abort code is withdrawn.

// File: rtl/nsr_pkg.sv
package nsr_pkg;

   typedef enum logic [2:0] {
      OP_IDLE   = 3'd0,
      OP_PROG   = 3'd1,
      OP_BERASE = 3'd2,
      OP_CERASE = 3'd3,
      OP_BLANK  = 3'd4,
      OP_SUSP   = 3'd5,
      OP_ABORT  = 3'd6,
      OP_RSVD   = 3'd7
   } nsr_op_e;

   localparam int STAT_W = 8;

   function automatic logic is_busy(input nsr_op_e op);
      return (op == OP_PROG) || (op == OP_BERASE) ||
             (op == OP_CERASE) || (op == OP_BLANK);
   endfunction

   function automatic logic is_erase_like(input nsr_op_e op);
      return (op == OP_BERASE) || (op == OP_CERASE) || (op == OP_SUSP);
   endfunction

endpackage

// File: rtl/nsr_read_detect.sv
module nsr_read_detect #(
   parameter bit STROBE_EDGE = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic rd_strobe,
   output logic rd_ev
);

   generate
      if (STROBE_EDGE) begin : g_edge
         logic strobe_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) strobe_q <= 1'b0;
            else        strobe_q <= rd_strobe;
         end
         assign rd_ev = rd_strobe & ~strobe_q;

         a_r13_single_event: assert property (@(posedge clk) disable iff (!rst_n)
            rd_ev |=> !rd_ev);
      end else begin : g_level
         assign rd_ev = rd_strobe;
      end
   endgenerate

endmodule

// File: rtl/nsr_mode_track.sv
module nsr_mode_track
   import nsr_pkg::*;
(
   input  logic    clk,
   input  logic    rst_n,
   input  nsr_op_e op,
   input  logic    in_blk,
   input  logic    sus_done,
   input  logic    abort_rst,
   output logic    start_op,
   output logic    abort_act,
   output logic    t6_en,
   output logic    t2_en
);

   nsr_op_e prev_op;
   logic    abort_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_op <= OP_IDLE;
      else        prev_op <= op;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              abort_q <= 1'b0;
      else if (op == OP_ABORT) abort_q <= 1'b1;
      else if (abort_rst)      abort_q <= 1'b0;
   end

   assign abort_act = (op == OP_ABORT) | abort_q;
   assign start_op  = is_busy(op) &&
                      ((prev_op == OP_IDLE) || (prev_op == OP_RSVD));
   assign t6_en     = !abort_act &&
                      (is_busy(op) || ((op == OP_SUSP) && in_blk && !sus_done));
   assign t2_en     = !abort_act && is_erase_like(op) && in_blk;

   a_r10_abort_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (abort_q && !abort_rst) |=> abort_q);
   a_r10_abort_set: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_ABORT) |=> abort_act);

endmodule

// File: rtl/nsr_toggle_bank.sv
module nsr_toggle_bank (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic rd_ev,
   input  logic t6_en,
   input  logic t2_en,
   output logic t6,
   output logic t2
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         t6 <= 1'b0;
         t2 <= 1'b0;
      end else if (clr) begin
         t6 <= 1'b0;
         t2 <= 1'b0;
      end else begin
         if (rd_ev && t6_en) t6 <= ~t6;
         if (rd_ev && t2_en) t2 <= ~t2;
      end
   end

   a_r4_b6_flip: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_ev && t6_en && !clr) |=> (t6 != $past(t6)));
   a_r7_b2_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!t2_en && !clr) |=> $stable(t2));
   a_r12_clear: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (!t6 && !t2));

endmodule

// File: rtl/nsr_status_mux.sv
module nsr_status_mux
   import nsr_pkg::*;
(
   input  nsr_op_e             op,
   input  logic                abort_act,
   input  logic                in_blk,
   input  logic                op_fail,
   input  logic                prog_bit,
   input  logic                erase_running,
   input  logic                t6,
   input  logic                t2,
   output logic [STAT_W-1:0]   stat,
   output logic                is_status
);

   always_comb begin
      stat      = '0;
      is_status = 1'b1;
      if (abort_act) begin
         stat = {~prog_bit, t6, 1'b0, 1'b0, 1'b0, t2, 1'b1, 1'b0};
      end else begin
         unique case (op)
            OP_PROG:   stat = {~prog_bit, t6, op_fail, 1'b0, 1'b0, t2, 2'b00};
            OP_BERASE: stat = {1'b0, t6, op_fail, 1'b0, erase_running, t2, 2'b00};
            OP_CERASE: stat = {1'b0, t6, op_fail, 1'b0, 1'b1, t2, 2'b00};
            OP_BLANK:  stat = {1'b0, t6, op_fail, 1'b0, 1'b0, t2, 2'b00};
            OP_SUSP: begin
               stat      = {1'b0, t6, 1'b0, 1'b0, 1'b1, t2, 2'b00};
               is_status = in_blk;
            end
            default:   is_status = 1'b0;
         endcase
      end
   end

endmodule

// File: rtl/nor_status_responder.sv
module nor_status_responder
   import nsr_pkg::*;
#(
   parameter int DW          = 16,
   parameter bit STROBE_EDGE = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [2:0]    op_state,
   input  logic          op_fail,
   input  logic          prog_bit,
   input  logic          erase_running,
   input  logic          suspend_done,
   input  logic          abort_rst,
   input  logic          rd_strobe,
   input  logic          rd_in_erase_blk,
   input  logic [DW-1:0] arr_data,
   output logic [DW-1:0] dout
);

   localparam int PAD_W = DW - STAT_W;

   generate
      if (DW < STAT_W) begin : g_bad_width
         $error("nor_status_responder: DW must be at least 8");
      end
   endgenerate

   nsr_op_e           op;
   logic              rd_ev, start_op, abort_act, t6_en, t2_en, t6, t2;
   logic              is_status;
   logic [STAT_W-1:0] stat;
   logic [DW-1:0]     stat_ext;

   assign op = nsr_op_e'(op_state);

   nsr_read_detect #(.STROBE_EDGE(STROBE_EDGE)) u_rd (
      .clk(clk), .rst_n(rst_n), .rd_strobe(rd_strobe), .rd_ev(rd_ev));

   nsr_mode_track u_mode (
      .clk(clk), .rst_n(rst_n), .op(op), .in_blk(rd_in_erase_blk),
      .sus_done(suspend_done), .abort_rst(abort_rst), .start_op(start_op),
      .abort_act(abort_act), .t6_en(t6_en), .t2_en(t2_en));

   nsr_toggle_bank u_tog (
      .clk(clk), .rst_n(rst_n), .clr(start_op), .rd_ev(rd_ev),
      .t6_en(t6_en), .t2_en(t2_en), .t6(t6), .t2(t2));

   nsr_status_mux u_mux (
      .op(op), .abort_act(abort_act), .in_blk(rd_in_erase_blk),
      .op_fail(op_fail), .prog_bit(prog_bit), .erase_running(erase_running),
      .t6(t6), .t2(t2), .stat(stat), .is_status(is_status));

   generate
      if (PAD_W > 0) begin : g_pad
         assign stat_ext = {{PAD_W{1'b0}}, stat};
      end else begin : g_nopad
         assign stat_ext = stat;
      end
   endgenerate

   assign dout = is_status ? stat_ext : arr_data;

   a_r1_idle_array: assert property (@(posedge clk) disable iff (!rst_n)
      (!abort_act && ((op == OP_IDLE) || (op == OP_RSVD))) |-> (dout == arr_data));
   a_r2_prog_bit7: assert property (@(posedge clk) disable iff (!rst_n)
      (!abort_act && (op == OP_PROG)) |-> (dout[7] == ~prog_bit));
   a_r8_susp_array: assert property (@(posedge clk) disable iff (!rst_n)
      (!abort_act && (op == OP_SUSP) && !rd_in_erase_blk) |-> (dout == arr_data));
   a_r11_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
      is_status |-> (!dout[4] && !dout[0] && ((dout >> STAT_W) == '0)));

endmodule

// File: tb/nor_status_responder_tb.sv
`timescale 1ns/100ps
module nor_status_responder_tb;

   localparam int DW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [2:0]    op_state = 3'd0;
   logic          op_fail = 1'b0, prog_bit = 1'b0, erase_running = 1'b0;
   logic          suspend_done = 1'b0, abort_rst = 1'b0;
   logic          rd_strobe = 1'b0, rd_in_erase_blk = 1'b0;
   logic [DW-1:0] arr_data = 16'h1234;
   logic [DW-1:0] dout;

   always #2.5 clk = ~clk;

   nor_status_responder #(.DW(DW)) u_dut (
      .clk(clk), .rst_n(rst_n), .op_state(op_state), .op_fail(op_fail),
      .prog_bit(prog_bit), .erase_running(erase_running),
      .suspend_done(suspend_done), .abort_rst(abort_rst),
      .rd_strobe(rd_strobe), .rd_in_erase_blk(rd_in_erase_blk),
      .arr_data(arr_data), .dout(dout));

   typedef struct {
      logic [DW-1:0] exp;
      string         tag;
   } item_t;

   item_t q[$];
   int    checks = 0, errors = 0;
   bit    done = 1'b0;
   logic  m6 = 1'b0, m2 = 1'b0, mabort = 1'b0;

   function automatic logic [DW-1:0] expv();
      logic [7:0] s;
      if (mabort) return {8'h00, ~prog_bit, m6, 3'b000, m2, 2'b10};
      case (op_state)
         3'd1: s = {~prog_bit, m6, op_fail, 2'b00, m2, 2'b00};
         3'd2: s = {1'b0, m6, op_fail, 1'b0, erase_running, m2, 2'b00};
         3'd3: s = {1'b0, m6, op_fail, 1'b0, 1'b1, m2, 2'b00};
         3'd4: s = {1'b0, m6, op_fail, 2'b00, m2, 2'b00};
         3'd5: begin
            if (!rd_in_erase_blk) return arr_data;
            s = {1'b0, m6, 3'b001, m2, 2'b00};
         end
         default: return arr_data;
      endcase
      return {8'h00, s};
   endfunction

   function automatic logic busy(input logic [2:0] o);
      return (o >= 3'd1) && (o <= 3'd4);
   endfunction

   task automatic compare(input logic [DW-1:0] got, input logic [DW-1:0] exp,
                          input string tag);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: dout=%h expected %h", tag, got, exp);
      end
   endtask

   // monitor: pops one scoreboard item per cycle with the strobe high
   always @(negedge clk) begin
      #1;
      if (rd_strobe && q.size() > 0) begin
         item_t it;
         it = q.pop_front();
         compare(dout, it.exp, it.tag);
      end
   end

   task automatic update_model();
      if (!mabort) begin
         if (busy(op_state) || (op_state == 3'd5 && rd_in_erase_blk && !suspend_done))
            m6 = ~m6;
         if ((op_state == 3'd2 || op_state == 3'd3 || op_state == 3'd5) && rd_in_erase_blk)
            m2 = ~m2;
      end
   endtask

   task automatic rd(input string tag);
      item_t it;
      @(negedge clk);
      it.exp = expv();
      it.tag = tag;
      q.push_back(it);
      rd_strobe = 1'b1;
      update_model();
      @(negedge clk);
      rd_strobe = 1'b0;
   endtask

   task automatic set_op(input logic [2:0] o);
      @(negedge clk);
      if (busy(o) && (op_state == 3'd0 || op_state == 3'd7) && !mabort) begin
         m6 = 1'b0;
         m2 = 1'b0;
      end
      if (o == 3'd6) mabort = 1'b1;
      op_state = o;
   endtask

   task automatic chk_now(input string tag);
      @(negedge clk);
      #1;
      compare(dout, expv(), tag);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      chk_now("R1 reset idle");

      // program, bit7 inverted, bit6 alternates from 0
      prog_bit = 1'b1;
      set_op(3'd1);
      rd("R2 R4 prog read0");
      rd_in_erase_blk = 1'b1;
      rd("R4 prog read1 in-block");
      rd_in_erase_blk = 1'b0;
      rd("R4 prog read2");
      prog_bit = 1'b0;
      op_fail = 1'b1;
      rd("R5 prog fail");
      op_fail = 1'b0;

      // held strobe counts once
      @(negedge clk);
      begin
         item_t it;
         it.exp = expv(); it.tag = "R13 held c0"; q.push_back(it);
         rd_strobe = 1'b1;
         update_model();
         for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            it.exp = expv(); it.tag = "R13 held later"; q.push_back(it);
         end
         @(negedge clk);
         rd_strobe = 1'b0;
      end
      rd("R13 after hold");

      set_op(3'd0);
      arr_data = 16'hBEEF;
      chk_now("R1 idle after program");
      set_op(3'd7);
      arr_data = 16'h0F0F;
      chk_now("R1 code 7 idle");

      // block erase
      set_op(3'd2);
      rd("R12 R3 berase first");
      rd("R6 berase window");
      erase_running = 1'b1;
      rd_in_erase_blk = 1'b1;
      rd("R6 R7 berase running in-blk");
      rd_in_erase_blk = 1'b0;
      rd("R7 berase out-blk");
      rd_in_erase_blk = 1'b1;
      rd("R7 berase in-blk");

      // suspend
      set_op(3'd5);
      rd_in_erase_blk = 1'b0;
      arr_data = 16'hC3A5;
      rd("R8 suspend out-blk array");
      rd_in_erase_blk = 1'b1;
      rd("R9 suspend in-blk");
      rd("R9 suspend in-blk 2");
      suspend_done = 1'b1;
      rd("R9 suspend settled");
      rd("R9 suspend settled hold");
      suspend_done = 1'b0;

      // resume keeps phase
      set_op(3'd2);
      rd("R12 resume no clear");
      erase_running = 1'b0;
      set_op(3'd0);

      // chip erase with failure
      set_op(3'd3);
      rd_in_erase_blk = 1'b0;
      rd("R6 R3 chip erase");
      op_fail = 1'b1;
      rd_in_erase_blk = 1'b1;
      rd("R5 chip erase fail");
      op_fail = 1'b0;
      set_op(3'd0);

      // blank check
      set_op(3'd4);
      rd("R3 blank");
      rd_in_erase_blk = 1'b1;
      op_fail = 1'b1;
      rd("R5 R7 blank fail");
      op_fail = 1'b0;
      set_op(3'd0);

      // abort latch
      set_op(3'd1);
      prog_bit = 1'b1;
      rd("R4 prog before abort");
      set_op(3'd6);
      rd("R10 abort status");
      rd("R10 abort frozen");
      set_op(3'd0);
      arr_data = 16'h5A5A;
      rd("R10 R11 abort held in idle");
      @(negedge clk);
      abort_rst = 1'b1;
      @(negedge clk);
      abort_rst = 1'b0;
      mabort = 1'b0;
      chk_now("R10 R1 abort cleared");

      repeat (4) @(negedge clk);
      if (q.size() != 0) begin
         checks++;
         errors++;
         $display("FAIL scoreboard: %0d items left, expected 0", q.size());
      end
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #200000;
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: run hung, expected completion");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule